// File: doc/BRIEF.md
# SDRAM Burst Data Path with Byte-Lane Masking

This block sits between a memory command controller and the 64-bit data pins of a synchronous DRAM. When the controller issues a read or write column command it pulses a launch strobe together with the start column; from that cycle on the block produces one beat per clock, generating the column of each beat in sequential or interleaved order, for a burst of 1, 2, 4 or 8 beats or an open-ended full-page burst that wraps inside a 1024-column page. A stop strobe ends the running burst, and a new launch may arrive on any cycle, including in the middle of a burst.

For writes the block drives the host's data onto the bus with an output enable and drives the eight byte-lane mask lines in the same cycle, because the memory applies write masks with zero latency. For reads it accepts a per-beat lane mask from the host, delays it so it reaches the memory two clocks before the data it blanks (the memory's read mask latency), and aligns the returning data to the programmed CAS latency of 2 or 3 clocks, presenting it with a valid flag and with masked lanes forced to zero.

Top module: `sdr_burst_path`

## Requirements
- R1: While reset is asserted, beat_o, dq_oe_o and rd_valid_o are 0 and dqm_o is all ones.
- R2: cfg_bl_i selects the burst length at launch: 3'b000 one beat, 3'b001 two, 3'b010 four, 3'b011 eight, 3'b111 full page; any other code gives one beat. Beats occupy consecutive cycles starting in the launch cycle.
- R3: In sequential order (cfg_ilv_i = 0) beat k addresses column start with its low log2(length) bits replaced by (start + k) modulo the length.
- R4: In interleaved order (cfg_ilv_i = 1) beat k addresses column start XOR k for lengths 2, 4 and 8.
- R5: A full-page burst is always sequential, addresses (start + k) modulo 1024 and continues until a stop or a new launch.
- R6: stop_i without a launch in the same cycle produces no beat in that cycle or later in the burst; a launch together with stop_i starts the new burst.
- R7: A launch during a running burst starts the new burst in that same cycle with no idle cycle.
- R8: In a write beat dq_oe_o is 1, dq_o equals wr_data_i and dqm_o equals wr_mask_i in that same cycle.
- R9: A read beat in cycle t produces rd_valid_o in cycle t+CL (CL = 3 when cfg_cas3_i = 1, else 2) with rd_data_o taken from dq_i in that cycle; no other cycle has rd_valid_o.
- R10: The rd_mask_i given with a read beat in cycle t appears on dqm_o in cycle t+CL-2, and each set bit n zeroes byte n (bits 8n+7..8n) of rd_data_o in cycle t+CL.
- R11: dqm_o is all ones when no write beat and no read mask is due; a write beat's mask takes priority over a read mask due in the same cycle.
- R12: When rd_launch_i and wr_launch_i are both high, the burst is a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_bl_i | input | 3 | Burst length code, sampled at launch |
| cfg_ilv_i | input | 1 | 1 = interleaved order, sampled at launch |
| cfg_cas3_i | input | 1 | 1 = CAS latency 3, 0 = CAS latency 2 |
| rd_launch_i | input | 1 | Read column command issued this cycle |
| wr_launch_i | input | 1 | Write column command issued this cycle |
| start_col_i | input | 10 | Start column of the launched burst |
| stop_i | input | 1 | Burst stop issued this cycle |
| wr_data_i | input | 64 | Host write data for the current beat |
| wr_mask_i | input | 8 | Host write lane mask for the current beat |
| rd_mask_i | input | 8 | Host read lane mask for the current beat |
| dq_i | input | 64 | Data from the memory pins |
| col_o | output | 10 | Column of the current beat |
| beat_o | output | 1 | A burst beat occurs this cycle |
| beat_wr_o | output | 1 | The current beat is a write |
| dq_o | output | 64 | Data to the memory pins |
| dq_oe_o | output | 1 | Output enable for dq_o |
| dqm_o | output | 8 | Byte-lane mask lines to the memory |
| rd_data_o | output | 64 | Aligned read data, masked lanes zero |
| rd_valid_o | output | 1 | rd_data_o holds a read beat |

## Verification
The hardest situation to reach is a CAS-latency-3 read whose last delayed mask lands in the same cycle as the first beat of a following write, where the two mask sources compete for dqm_o, together with a stop that lands while read beats are still in flight so that the valid flag must drop exactly CL cycles later. The stimulus issues a read immediately followed by a write launch, stops full-page reads and writes after a wrap across column 1023, relaunches in the middle of bursts, and randomises the data and both masks on every cycle, while a behavioural model with a short history of past read beats predicts every output each clock.

// File: rtl/sdr_dp_pkg.sv
package sdr_dp_pkg;
  typedef enum logic [2:0] {
    BL_ONE  = 3'b000,
    BL_TWO  = 3'b001,
    BL_FOUR = 3'b010,
    BL_EIGHT= 3'b011,
    BL_PAGE = 3'b111
  } bl_code_e;

  localparam int unsigned LANE_W = 8;
endpackage

// File: rtl/sdr_burst_seq.sv
module sdr_burst_seq
  import sdr_dp_pkg::*;
#(
  parameter int unsigned COL_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             launch_i,
  input  logic             launch_wr_i,
  input  logic             stop_i,
  input  logic [2:0]       bl_i,
  input  logic             ilv_i,
  input  logic [COL_W-1:0] start_i,
  output logic             beat_o,
  output logic             beat_wr_o,
  output logic [COL_W-1:0] col_o
);
  logic             act_q, wr_q, ilv_q;
  logic [COL_W-1:0] span_q, start_q, cnt_q;

  logic [COL_W-1:0] in_span, sel_span, sel_start, sel_idx, seq_col;
  logic             sel_ilv, in_page;

  // span = burst length - 1, all ones for a page burst
  always_comb begin
    unique case (bl_code_e'(bl_i))
      BL_TWO:   in_span = COL_W'(1);
      BL_FOUR:  in_span = COL_W'(3);
      BL_EIGHT: in_span = COL_W'(7);
      BL_PAGE:  in_span = '1;
      default:  in_span = '0;
    endcase
  end
  assign in_page = &in_span;

  always_comb begin
    if (launch_i) begin
      sel_span  = in_span;
      sel_start = start_i;
      sel_idx   = '0;
      sel_ilv   = ilv_i & ~in_page;
      beat_o    = 1'b1;
      beat_wr_o = launch_wr_i;
    end else begin
      sel_span  = span_q;
      sel_start = start_q;
      sel_idx   = cnt_q;
      sel_ilv   = ilv_q;
      beat_o    = act_q & ~stop_i;
      beat_wr_o = act_q & ~stop_i & wr_q;
    end
  end

  assign seq_col = (sel_start & ~sel_span) | ((sel_start + sel_idx) & sel_span);
  assign col_o   = sel_ilv ? (sel_start ^ sel_idx) : seq_col;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q   <= 1'b0;
      wr_q    <= 1'b0;
      ilv_q   <= 1'b0;
      span_q  <= '0;
      start_q <= '0;
      cnt_q   <= '0;
    end else if (launch_i) begin
      act_q   <= |in_span;
      wr_q    <= launch_wr_i;
      ilv_q   <= ilv_i & ~in_page;
      span_q  <= in_span;
      start_q <= start_i;
      cnt_q   <= COL_W'(1);
    end else if (act_q) begin
      if (stop_i) begin
        act_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q + COL_W'(1);
        if (!(&span_q) && cnt_q == span_q) act_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sdr_rd_align.sv
module sdr_rd_align
  import sdr_dp_pkg::*;
#(
  parameter int unsigned LANES  = 8,
  parameter int unsigned MAX_CL = 3
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    beat_rd_i,
  input  logic [LANES-1:0]        mask_i,
  input  logic                    cas3_i,
  input  logic [LANES*LANE_W-1:0] dq_i,
  output logic [LANES-1:0]        rd_dqm_o,
  output logic [LANES*LANE_W-1:0] rd_data_o,
  output logic                    rd_valid_o
);
  logic [MAX_CL-1:0] vld_q;
  logic [LANES-1:0]  msk_q [MAX_CL];
  logic [LANES-1:0]  tap_msk;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q[0] <= 1'b0;
      msk_q[0] <= '1;
    end else begin
      vld_q[0] <= beat_rd_i;
      msk_q[0] <= mask_i;
    end
  end

  for (genvar k = 1; k < MAX_CL; k++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q[k] <= 1'b0;
        msk_q[k] <= '1;
      end else begin
        vld_q[k] <= vld_q[k-1];
        msk_q[k] <= msk_q[k-1];
      end
    end
  end

  // tap CL-1: the stage entered CL cycles after the beat
  assign rd_valid_o = cas3_i ? vld_q[2] : vld_q[1];
  assign tap_msk    = cas3_i ? msk_q[2] : msk_q[1];

  // read mask must lead its data by two cycles
  always_comb begin
    if (cas3_i) rd_dqm_o = vld_q[0] ? msk_q[0] : '1;
    else        rd_dqm_o = beat_rd_i ? mask_i : '1;
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign rd_data_o[l*LANE_W +: LANE_W] =
      (rd_valid_o && !tap_msk[l]) ? dq_i[l*LANE_W +: LANE_W] : '0;
  end
endmodule

// File: rtl/sdr_burst_path.sv
module sdr_burst_path
  import sdr_dp_pkg::*;
#(
  parameter int unsigned DATA_W    = 64,
  parameter int unsigned PAGE_COLS = 1024,
  localparam int unsigned LANES    = DATA_W / LANE_W,
  localparam int unsigned COL_W    = $clog2(PAGE_COLS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        cfg_bl_i,
  input  logic              cfg_ilv_i,
  input  logic              cfg_cas3_i,
  input  logic              rd_launch_i,
  input  logic              wr_launch_i,
  input  logic [COL_W-1:0]  start_col_i,
  input  logic              stop_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [LANES-1:0]  wr_mask_i,
  input  logic [LANES-1:0]  rd_mask_i,
  input  logic [DATA_W-1:0] dq_i,
  output logic [COL_W-1:0]  col_o,
  output logic              beat_o,
  output logic              beat_wr_o,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe_o,
  output logic [LANES-1:0]  dqm_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_valid_o
);
  logic             beat_rd;
  logic [LANES-1:0] rd_dqm;

  sdr_burst_seq #(.COL_W(COL_W)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .launch_i    (rd_launch_i | wr_launch_i),
    .launch_wr_i (wr_launch_i),
    .stop_i      (stop_i),
    .bl_i        (cfg_bl_i),
    .ilv_i       (cfg_ilv_i),
    .start_i     (start_col_i),
    .beat_o      (beat_o),
    .beat_wr_o   (beat_wr_o),
    .col_o       (col_o)
  );

  assign beat_rd = beat_o & ~beat_wr_o;

  sdr_rd_align #(.LANES(LANES), .MAX_CL(3)) u_align (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .beat_rd_i  (beat_rd),
    .mask_i     (rd_mask_i),
    .cas3_i     (cfg_cas3_i),
    .dq_i       (dq_i),
    .rd_dqm_o   (rd_dqm),
    .rd_data_o  (rd_data_o),
    .rd_valid_o (rd_valid_o)
  );

  assign dq_oe_o = beat_wr_o;
  assign dq_o    = beat_wr_o ? wr_data_i : '0;
  assign dqm_o   = beat_wr_o ? wr_mask_i : rd_dqm;
endmodule

// File: rtl/sdr_burst_path_chk.sv
module sdr_burst_path_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cfg_cas3_i,
  input logic       rd_launch_i,
  input logic       wr_launch_i,
  input logic       stop_i,
  input logic [7:0] wr_mask_i,
  input logic       beat_o,
  input logic       beat_wr_o,
  input logic       dq_oe_o,
  input logic [7:0] dqm_o,
  input logic       rd_valid_o
);
  p_stop_kills_beat_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && !rd_launch_i && !wr_launch_i) |-> !beat_o);

  p_wr_mask_same_cycle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_wr_o |-> (dq_oe_o && dqm_o == wr_mask_i));

  p_rd_valid_cl2_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_o && !beat_wr_o && !cfg_cas3_i && $stable(cfg_cas3_i)) |-> ##2 rd_valid_o);

  p_rd_valid_cl3_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_o && !beat_wr_o && cfg_cas3_i && $stable(cfg_cas3_i)) |-> ##3 rd_valid_o);

  p_valid_has_source_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> ($past(beat_o && !beat_wr_o, 2) || $past(beat_o && !beat_wr_o, 3)));

  p_idle_dqm_high_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!beat_o && !$past(beat_o)) |-> (dqm_o == 8'hFF));

  p_wr_launch_wins_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_launch_i && rd_launch_i) |-> beat_wr_o);
endmodule

bind sdr_burst_path sdr_burst_path_chk u_chk (.*);

// File: tb/sdr_burst_path_bench.sv
module sdr_burst_path_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  bl = 3'b000;
  logic        ilv = 1'b0, cas3 = 1'b0, rd_l = 1'b0, wr_l = 1'b0, stp = 1'b0;
  logic [9:0]  scol = '0;
  logic [63:0] wdat = '0, dqin = '0;
  logic [7:0]  wmsk = '0, rmsk = '0;
  logic        n_cas3 = 1'b0;

  logic [9:0]  col;
  logic        beat, beat_wr, dq_oe, rd_valid;
  logic [63:0] dq_out, rd_data;
  logic [7:0]  dqm;

  sdr_burst_path u_sdr_burst_path (
    .clk_i(clk), .rst_ni(rst_n), .cfg_bl_i(bl), .cfg_ilv_i(ilv), .cfg_cas3_i(cas3),
    .rd_launch_i(rd_l), .wr_launch_i(wr_l), .start_col_i(scol), .stop_i(stp),
    .wr_data_i(wdat), .wr_mask_i(wmsk), .rd_mask_i(rmsk), .dq_i(dqin),
    .col_o(col), .beat_o(beat), .beat_wr_o(beat_wr), .dq_o(dq_out), .dq_oe_o(dq_oe),
    .dqm_o(dqm), .rd_data_o(rd_data), .rd_valid_o(rd_valid)
  );

  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;

  // reference model state
  int m_act = 0, m_idx = 0, m_st = 0, m_len = 1, m_il = 0, m_wr = 0;
  int hist_rd [8];
  int hist_m  [8];
  int cyc = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s cycle %0d actual %0h expected %0h", req, cyc, act, exp);
    end
  endtask

  function automatic int len_of(input logic [2:0] c);
    case (c)
      3'b000: return 1;
      3'b001: return 2;
      3'b010: return 4;
      3'b011: return 8;
      3'b111: return 0;
      default: return 1;
    endcase
  endfunction

  task automatic tick(input bit r, input bit w, input bit s, input logic [2:0] b,
                      input bit il, input int c);
    int e_beat, e_wr, st, ln, eil, idx, e_col, e_rdb, cl, e_rdv, e_rdm, hp;
    logic [7:0]  e_dqm;
    logic [63:0] e_dat;
    string tg;
    @(negedge clk);
    rd_l = r; wr_l = w; stp = s; bl = b; ilv = il; scol = 10'(c); cas3 = n_cas3;
    wdat = {$urandom, $urandom}; dqin = {$urandom, $urandom};
    wmsk = 8'($urandom); rmsk = 8'($urandom);
    #1;
    e_beat = 0; e_wr = 0; st = 0; ln = 1; eil = 0; idx = 0;
    if (r || w) begin
      e_beat = 1; e_wr = w; st = c; ln = len_of(b); eil = il && ln != 0; idx = 0;
    end else if (m_act != 0 && !s) begin
      e_beat = 1; e_wr = m_wr; st = m_st; ln = m_len; eil = m_il; idx = m_idx;
    end
    if (ln == 0) e_col = (st + idx) % 1024;
    else if (eil != 0) e_col = (st - st % ln) + ((st % ln) ^ idx);
    else e_col = (st - st % ln) + ((st % ln + idx) % ln);
    e_rdb = e_beat && !e_wr;
    cl = cas3 ? 3 : 2;
    e_rdv = hist_rd[(cyc - cl) & 7];
    e_rdm = hist_m[(cyc - cl) & 7];
    hp = hist_rd[(cyc - 1) & 7];
    if (e_beat && e_wr) e_dqm = wmsk;
    else if (cas3) e_dqm = hp ? 8'(hist_m[(cyc - 1) & 7]) : 8'hFF;
    else e_dqm = e_rdb ? rmsk : 8'hFF;
    e_dat = '0;
    for (int l = 0; l < 8; l++)
      if (e_rdv != 0 && !e_rdm[l]) e_dat[l*8 +: 8] = dqin[l*8 +: 8];

    tg = s ? "R6" : ((r || w) && m_act != 0) ? "R7" : "R2";
    chk(beat == e_beat[0], tg, longint'(beat), longint'(e_beat));
    tg = (r && w) ? "R12" : "R8";
    chk(beat_wr == e_wr[0] || !e_beat, tg, longint'(beat_wr), longint'(e_wr));
    if (e_beat != 0) begin
      tg = (ln == 0) ? "R5" : (eil != 0) ? "R4" : "R3";
      chk(col == 10'(e_col), tg, longint'(col), longint'(e_col));
    end
    chk(dq_oe == (e_beat && e_wr), "R8", longint'(dq_oe), longint'(e_beat && e_wr));
    if (e_beat && e_wr) chk(dq_out == wdat, "R8", longint'(dq_out), longint'(wdat));
    tg = (e_beat && e_wr) ? ((cas3 && hp) ? "R11" : "R8") :
         (dqm != 8'hFF || e_dqm != 8'hFF) ? "R10" : "R11";
    chk(dqm == e_dqm, tg, longint'(dqm), longint'(e_dqm));
    chk(rd_valid == e_rdv[0], "R9", longint'(rd_valid), longint'(e_rdv));
    if (e_rdv != 0) begin
      tg = (e_rdm[7:0] != 0) ? "R10" : "R9";
      chk(rd_data == e_dat, tg, longint'(rd_data), longint'(e_dat));
    end

    @(posedge clk);
    hist_rd[cyc & 7] = e_rdb;
    hist_m[cyc & 7]  = int'(rmsk);
    if (r || w) begin
      m_act = (ln != 1); m_idx = 1; m_st = c; m_len = ln; m_il = eil; m_wr = w;
    end else if (m_act != 0) begin
      if (s) m_act = 0;
      else begin
        m_idx++;
        if (m_len != 0 && m_idx == m_len) m_act = 0;
      end
    end
    cyc++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick(0, 0, 0, 3'b000, 0, 0);
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) tick(0, 0, 0, 3'b000, 0, 0);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) begin hist_rd[i] = 0; hist_m[i] = 0; end
    #23;
    // R1: reset state
    checks++; if (beat !== 1'b0) begin errors++; $display("FAIL R1 beat actual %0h expected 0", beat); end
    checks++; if (dq_oe !== 1'b0) begin errors++; $display("FAIL R1 dq_oe actual %0h expected 0", dq_oe); end
    checks++; if (rd_valid !== 1'b0) begin errors++; $display("FAIL R1 rd_valid actual %0h expected 0", rd_valid); end
    checks++; if (dqm !== 8'hFF) begin errors++; $display("FAIL R1 dqm actual %0h expected ff", dqm); end
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk);

    // CL2 sequential reads
    n_cas3 = 0;
    tick(1, 0, 0, 3'b010, 0, 5);  run(5);
    tick(1, 0, 0, 3'b011, 0, 13); run(9);
    // interleaved reads
    tick(1, 0, 0, 3'b011, 1, 13); run(9);
    tick(1, 0, 0, 3'b010, 1, 6);  run(5);
    tick(1, 0, 0, 3'b001, 1, 7);  run(3);
    // writes
    tick(0, 1, 0, 3'b011, 0, 6);  run(9);
    tick(0, 1, 0, 3'b010, 1, 9);  run(5);
    // back-to-back BL1/BL2 every cycle (R7)
    for (int i = 0; i < 6; i++) tick(1, 0, 0, (i % 2) ? 3'b001 : 3'b000, 0, 40 + i);
    run(4);
    // relaunch mid-burst
    tick(1, 0, 0, 3'b011, 0, 100); run(2);
    tick(0, 1, 0, 3'b010, 1, 201); run(5);
    // unsupported codes act as length 1 (R2)
    tick(1, 0, 0, 3'b100, 0, 3); run(2);
    tick(0, 1, 0, 3'b101, 1, 3); run(3);
    // both launches (R12)
    tick(1, 1, 0, 3'b010, 0, 17); run(5);
    // full page write wrapping then stop (R5, R6)
    tick(0, 1, 0, 3'b111, 1, 1020); run(9);
    tick(0, 0, 1, 3'b000, 0, 0); run(3);
    // full page read stopped mid-burst
    tick(1, 0, 0, 3'b111, 0, 1022); run(5);
    tick(0, 0, 1, 3'b000, 0, 0); run(4);
    // stop with launch in the same cycle
    tick(1, 0, 0, 3'b011, 0, 50); run(2);
    tick(1, 0, 1, 3'b010, 0, 61); run(5);
    // stop on a BL8 burst, stop when idle
    tick(0, 1, 0, 3'b011, 0, 70); run(2);
    tick(0, 0, 1, 3'b000, 0, 0); tick(0, 0, 1, 3'b000, 0, 0); run(3);

    // CL3
    n_cas3 = 1; idle(4);
    tick(1, 0, 0, 3'b010, 0, 5);  run(6);
    tick(1, 0, 0, 3'b011, 1, 11); run(10);
    // read immediately followed by write (R11 priority)
    tick(1, 0, 0, 3'b001, 0, 30); tick(0, 1, 0, 3'b010, 0, 32); run(6);
    tick(1, 0, 0, 3'b000, 0, 30); tick(0, 1, 0, 3'b000, 0, 31); run(5);
    // full page read with stop under CL3
    tick(1, 0, 0, 3'b111, 0, 1019); run(7);
    tick(0, 0, 1, 3'b000, 0, 0); run(5);
    // continuous back-to-back reads
    for (int i = 0; i < 8; i++) tick(1, 0, 0, 3'b000, 0, 300 + i);
    run(5);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1500000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule